// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset

This block produces the active-low reset that holds a host processor in a known state. Two causes can start a reset. One is a supply fault: a synchronized flag from an external comparator reports that the rail is below its trip level. The other is a watchdog expiry: the host has failed to kick the watchdog in time. Every reset is stretched by a fixed hold interval, counted in clock cycles, before it is released. The reset pad is open-drain, so the block provides only a pull-low enable. A second output tells whether the reset in progress was caused by the watchdog.

The host kicks the watchdog with a falling edge on an input that it shares with a serial chip select. The input is synchronized before the edge is detected, and a rising edge has no effect. If the input stays high or stays low for the whole timeout, the watchdog still expires. A two-bit select picks one of three timeout lengths or turns the watchdog off, and a separate enable can also turn it off. While the supply flag is set, the watchdog counter is kept at zero, so a supply fault takes priority over a watchdog expiry.

Top module: `supply_supervisor`

## Requirements
- R1: When `supply_low` is sampled high at a clock edge, `rst_pull_low` is 1 after that edge and stays 1 for as long as the flag stays high.
- R2: `rst_pull_low` returns to 0 exactly HOLD_CYC edges after the last edge at which `supply_low` was sampled high.
- R3: While `rst_n` is low, `rst_pull_low` is 1 and `wd_cause` is 0. With the supply good, the reset is released HOLD_CYC edges after the last edge at which `rst_n` was low.
- R4: A high-to-low transition on `kick_cs` passes through a two-stage synchronizer and clears the watchdog count at the third edge after the input changes. The next expiry is then a full timeout later.
- R5: With the watchdog armed and no falling edge on `kick_cs`, `rst_pull_low` rises exactly one timeout (in cycles) after the counter starts from zero. This holds whether `kick_cs` stays high or stays low.
- R6: `tmo_sel` = 2'b00 selects TMO0_CYC, 2'b01 selects TMO1_CYC, and 2'b10 selects TMO2_CYC.
- R7: When `tmo_sel` = 2'b11 or `wd_en` = 0, the watchdog never asserts the reset and its counter stays at zero.
- R8: A watchdog reset holds `rst_pull_low` and `wd_cause` at 1 for HOLD_CYC cycles. After release, the counter restarts from zero, so the next expiry comes one full timeout after the release.
- R9: While `supply_low` is set, the watchdog counter is held at zero and `wd_cause` is 0. This holds even if a watchdog reset is already in progress.
- R10: A low-to-high transition on `kick_cs` does not restart the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_low | input | 1 | Synchronized flag: supply is below the trip level |
| kick_cs | input | 1 | Watchdog kick input, shared with the serial chip select (asynchronous) |
| wd_en | input | 1 | Watchdog enable |
| tmo_sel | input | 2 | Timeout select; 2'b11 disables the watchdog |
| rst_pull_low | output | 1 | Open-drain enable: 1 pulls the reset pad low |
| wd_cause | output | 1 | 1 while a watchdog-caused reset is being held |

## Verification
The bench builds the block with HOLD_CYC = 20 and timeouts of 8, 16 and 40 cycles. With these values, every stretch and every watchdog expiry finishes within a few hundred cycles. Because the three timeouts differ, a swapped select is visible at a specific cycle. The short hold also makes it possible to test overlapping causes: a supply fault during a watchdog hold, and a watchdog that would otherwise have expired during a supply fault. Each of these is checked at the exact cycle where the output must change.

// File: rtl/sup_pkg.sv
// Package: shared types and helpers for the supply supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package sup_pkg;

    // Which source started the reset in progress
    typedef enum logic {
        CAUSE_SUPPLY = 1'b0,
        CAUSE_WDOG   = 1'b1
    } rst_cause_e;

    // Timeout select code that turns the watchdog off
    localparam logic [1:0] SEL_OFF = 2'b11;

    // Largest of three cycle counts, used to size the watchdog counter
    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/kick_sync.sv
// Module: kick_sync
// Synchronizes the asynchronous kick / chip-select input through a chain of
// flops and emits a one-cycle pulse on each high-to-low transition of the
// synchronized value. Assumes the input idles high (deselected bus).
module kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_in,
    output logic kick_fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchronizer stages: stage 0 samples the pin, the others follow
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop of the chain samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= kick_in;
                end
            end else begin : g_next
                // Later flops follow the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    // Falling edge: was high, now low
    always_comb kick_fall = prev & ~chain[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        kick_fall |=> !kick_fall); // R4

endmodule

// File: rtl/wd_timer.sv
// Module: wd_timer
// Watchdog counter. Counts clock cycles while armed. It clears on a kick,
// while disarmed, and while a reset is held. It raises expire in the cycle
// the count reaches the selected timeout, so that the reset begins at the
// next edge. Assumes the timeouts are at least 2 cycles.
module wd_timer
    import sup_pkg::*;
#(
    parameter int unsigned TMO0_CYC = 8,
    parameter int unsigned TMO1_CYC = 16,
    parameter int unsigned TMO2_CYC = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       wd_en,
    input  logic [1:0] tmo_sel,
    input  logic       kick_fall,
    output logic       expire
);

    localparam int unsigned MAX_TMO = max3(TMO0_CYC, TMO1_CYC, TMO2_CYC);
    localparam int          CW      = $clog2(MAX_TMO + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit_m1;
    logic          armed;

    // Pick the terminal count for the selected timeout
    always_comb begin
        unique case (tmo_sel)
            2'b00:   limit_m1 = CW'(TMO0_CYC - 1);
            2'b01:   limit_m1 = CW'(TMO1_CYC - 1);
            default: limit_m1 = CW'(TMO2_CYC - 1);
        endcase
    end

    // Watchdog runs only when enabled, not switched off, and no reset is held
    always_comb armed = wd_en && (tmo_sel != SEL_OFF) && !hold;

    // Expiry when the count has reached the terminal value and no kick arrives
    always_comb expire = armed && !kick_fall && (cnt >= limit_m1);

    // Cycle counter with clear on kick, disarm, or expiry
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (!armed || kick_fall || expire) cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_sel == SEL_OFF || !wd_en) |=> (cnt == '0)); // R7

    AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_fall && !hold) |=> (cnt == '0)); // R4

endmodule

// File: rtl/hold_stretch.sv
// Module: hold_stretch
// Reset stretcher. Either cause starts or restarts the hold, and the supply
// fault wins when both are present. The reset is released after HOLD_CYC
// quiet edges. The cause register records which source started the current
// hold. Assumes HOLD_CYC >= 1.
module hold_stretch
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_low,
    input  logic       wd_expire,
    output logic       active,
    output rst_cause_e cause
);

    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hcnt;

    // Start, restart, or count down the reset hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            hcnt   <= '0;
            cause  <= CAUSE_SUPPLY;
        end else if (supply_low) begin
            active <= 1'b1;
            hcnt   <= '0;
            cause  <= CAUSE_SUPPLY;
        end else if (wd_expire) begin
            active <= 1'b1;
            hcnt   <= '0;
            cause  <= CAUSE_WDOG;
        end else if (active) begin
            if (hcnt == HW'(HOLD_CYC - 1)) begin
                active <= 1'b0;
                hcnt   <= '0;
            end else begin
                hcnt   <= hcnt + 1'b1;
            end
        end
    end

    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (hcnt < HW'(HOLD_CYC))); // R2

endmodule

// File: rtl/supply_supervisor.sv
// Module: supply_supervisor (top)
// Joins the kick synchronizer, the watchdog timer and the reset stretcher.
// It drives the enable of an open-drain reset pad and a watchdog-cause flag.
// Assumes supply_low is already synchronous to clk. All intervals are given
// in clock cycles.
module supply_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_CYC    = 25_000_000,
    parameter int unsigned TMO0_CYC    = 1_500_000,
    parameter int unsigned TMO1_CYC    = 20_000_000,
    parameter int unsigned TMO2_CYC    = 140_000_000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_low,
    input  logic       kick_cs,
    input  logic       wd_en,
    input  logic [1:0] tmo_sel,
    output logic       rst_pull_low,
    output logic       wd_cause
);

    logic       kick_fall;
    logic       wd_expire;
    logic       hold_active;
    logic       wd_hold;
    rst_cause_e cause;

    kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_in   (kick_cs),
        .kick_fall (kick_fall)
    );

    // Keep the watchdog cleared during any held reset or supply fault
    always_comb wd_hold = hold_active | supply_low;

    wd_timer #(
        .TMO0_CYC (TMO0_CYC),
        .TMO1_CYC (TMO1_CYC),
        .TMO2_CYC (TMO2_CYC)
    ) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (wd_hold),
        .wd_en     (wd_en),
        .tmo_sel   (tmo_sel),
        .kick_fall (kick_fall),
        .expire    (wd_expire)
    );

    hold_stretch #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .wd_expire  (wd_expire),
        .active     (hold_active),
        .cause      (cause)
    );

    // Pad enable and cause flag
    always_comb begin
        rst_pull_low = hold_active;
        wd_cause     = hold_active && (cause == CAUSE_WDOG);
    end

    AST_LOW_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> rst_pull_low); // R1

    AST_RELEASE_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull_low) |-> !$past(supply_low)); // R2

    AST_WD_FLAG_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        wd_cause |-> rst_pull_low); // R8

    AST_SUPPLY_BEATS_WD: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !wd_cause); // R9

endmodule

// File: tb/sim_supply_supervisor.sv
// Scoreboard bench: the driver queues expected output values per cycle,
// and a monitor pops and compares them at each falling clock edge.
module sim_supply_supervisor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_low = 1'b0;
    logic       kick_cs = 1'b1;
    logic       wd_en = 1'b1;
    logic [1:0] tmo_sel = 2'b00;
    logic       rst_pull_low;
    logic       wd_cause;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  pull;
        logic  wdc;
        string tag;
    } exp_t;

    exp_t sb[$];

    supply_supervisor #(
        .HOLD_CYC (20),
        .TMO0_CYC (8),
        .TMO1_CYC (16),
        .TMO2_CYC (40)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low   (supply_low),
        .kick_cs      (kick_cs),
        .wd_en        (wd_en),
        .tmo_sel      (tmo_sel),
        .rst_pull_low (rst_pull_low),
        .wd_cause     (wd_cause)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int at, logic pull, logic wdc, string tag);
        exp_t e;
        e.at = at; e.pull = pull; e.wdc = wdc; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic go_to(int n);
        while (cyc != n) @(negedge clk);
    endtask

    // Monitor: compare queued expectations at the matching cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at == cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (rst_pull_low !== e.pull || wd_cause !== e.wdc) begin
                n_bad++;
                $display("FAIL %s cyc=%0d: pull=%b wdc=%b expected pull=%b wdc=%b",
                         e.tag, cyc, rst_pull_low, wd_cause, e.pull, e.wdc);
            end
        end
    end

    // Driver: queue expectations, then apply stimulus
    initial begin
        expect_at(3,   1, 0, "R3 reset state");
        expect_at(22,  1, 0, "R3 still held");
        expect_at(23,  0, 0, "R3 release");
        expect_at(30,  0, 0, "R5 before expiry (kick high)");
        expect_at(31,  1, 1, "R5 expiry kick held high");
        expect_at(50,  1, 1, "R8 wd hold length");
        expect_at(51,  0, 0, "R8 wd release");
        expect_at(61,  0, 0, "R4 kick restarted count");
        expect_at(62,  1, 1, "R5 expiry kick held low");
        expect_at(97,  0, 0, "R10 before expiry");
        expect_at(98,  1, 1, "R10 rising edge ignored / R6 sel 01");
        expect_at(134, 0, 0, "R4 kick delays expiry");
        expect_at(143, 0, 0, "R4 before restarted expiry");
        expect_at(144, 1, 1, "R4 restarted expiry");
        expect_at(203, 0, 0, "R6 sel 10 before expiry");
        expect_at(204, 1, 1, "R6 sel 10 expiry");
        expect_at(300, 0, 0, "R7 sel 11 disables");
        expect_at(330, 0, 0, "R7 wd_en low disables");
        expect_at(337, 0, 0, "R6 sel 00 before expiry");
        expect_at(338, 1, 1, "R6 sel 00 expiry");
        expect_at(370, 0, 0, "R1 before fault");
        expect_at(371, 1, 0, "R1 fault asserts reset");
        expect_at(398, 1, 0, "R9 counter held during fault");
        expect_at(399, 1, 0, "R2 still held");
        expect_at(400, 0, 0, "R2 release after hold");
        expect_at(439, 0, 0, "R9 count restarted after fault");
        expect_at(440, 1, 1, "R8 next expiry full timeout");
        expect_at(446, 1, 0, "R9 fault overrides wd cause");
        expect_at(466, 1, 0, "R2 still held");
        expect_at(467, 0, 0, "R2 release after fault in wd hold");
        expect_at(470, 0, 0, "R2 stays released");

        go_to(3);   rst_n = 1'b1;
        go_to(51);  kick_cs = 1'b0;
        go_to(62);  tmo_sel = 2'b01;
        go_to(82);  kick_cs = 1'b1;
        go_to(125); kick_cs = 1'b0;
        go_to(150); tmo_sel = 2'b10;
        go_to(210); tmo_sel = 2'b11;
        go_to(300); tmo_sel = 2'b00; wd_en = 1'b0;
        go_to(330); wd_en = 1'b1;
        go_to(340); tmo_sel = 2'b10;
        go_to(370); supply_low = 1'b1;
        go_to(380); supply_low = 1'b0;
        go_to(445); supply_low = 1'b1;
        go_to(447); supply_low = 1'b0;
        go_to(480);
        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: end a hung run as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: cyc=%0d, expected end by 480", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule